// File: doc/BRIEF.md
# Credit-Based Transmit Flow Gate

This block sits in the transmit path of a serial link and decides, cycle by cycle, whether the packet at the head of the queue may leave. The receiver at the far end of the link advertises how much buffer space it has. The gate keeps that space in six pools: a header pool and a data pool for each of the posted, non-posted and completion traffic categories. A packet goes out only when both pools of its category can cover it. Nothing else pushes back on the transmitter. A short pool simply holds the packet until the receiver returns more credits.

During link bring-up the initial limits arrive one category at a time. An advertised value of zero marks a pool as unlimited, which is how the completion pools are normally set up. After bring-up, credit-return messages raise the limits of the named category. Every packet that is let through consumes one header credit and one data credit per started 4-byte word of payload. Consumption takes effect in the same cycle as the permit.

Top module: `tx_credit_gate`

## Requirements
- R1: Each category keeps its own header and data pools. Consuming credits of one category never changes whether a packet of another category is permitted.
- R2: Every permitted packet takes exactly one header credit, whatever its payload length. When the header pool of its category is empty, even a packet with no payload is refused.
- R3: A packet with `req_has_data`=1 and a length of L bytes needs ceil(L/4) data credits. A packet with `req_has_data`=0 needs none.
- R4: `send_ok` is high only when the header pool and the data pool of `req_cat` can both cover the request. Category codes are 0 posted, 1 non-posted and 2 completion. Code 3 is never permitted.
- R5: A credit-return message (`upd_valid` with `upd_cat`, `upd_hdr`, `upd_dat`) raises the limits of the named category from the next cycle on. When it coincides with a consume in the same category, both changes are kept.
- R6: A pool advertised with a value of 0 at initialisation is unlimited. It never refuses a request, it is never decremented, and credit returns leave it unchanged.
- R7: `send_ok` stays low until `init_done` has been seen. `init_done` opens the gate from the next cycle and keeps it open until reset. Initialisation messages that arrive after that are ignored.
- R8: The limit and consumed counters wrap modulo 2^8 for headers and modulo 2^12 for data. The available amount is (limit − consumed) mod 2^n, so availability stays correct when the limit counter has wrapped below the consumed counter.
- R9: `tx_take` is high exactly in the cycles where `req_valid` and `send_ok` are both high. That packet's credits are deducted from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_valid | input | 1 | Initial credit advertisement for one category |
| init_cat | input | 2 | Category of the advertisement |
| init_hdr | input | HDR_W | Initial header credits (0 means unlimited) |
| init_dat | input | DAT_W | Initial data credits (0 means unlimited) |
| init_done | input | 1 | Link initialisation complete |
| upd_valid | input | 1 | Credit-return message present |
| upd_cat | input | 2 | Category being returned |
| upd_hdr | input | HDR_W | Header credits returned |
| upd_dat | input | DAT_W | Data credits returned |
| req_valid | input | 1 | A packet is waiting to be sent |
| req_cat | input | 2 | Category of the waiting packet |
| req_has_data | input | 1 | Waiting packet carries a payload |
| req_len | input | LEN_W | Payload length in bytes |
| send_ok | output | 1 | Credits cover the waiting packet |
| tx_take | output | 1 | Packet sent this cycle, credits consumed |

## Verification
The bench drains a posted pool one header at a time. A gate that checked only data credits, or charged headers by size, would let a payload-free packet through an empty header pool. It sends lengths of 32, 33, 4 and 5 bytes against exact data balances, which catches a floor division or a byte-count comparison. It lands a credit return and a consume on the same edge. It pushes the non-posted header counter through a wrap, where a plain unsigned compare of limit against consumed would refuse packets the receiver can hold. Three further cases are covered: a late zero advertisement after bring-up that must not turn a drained pool unlimited, hundreds of maximum-length completions against unlimited pools, and the unused category code, which a gate indexing pools without a guard would let through.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  typedef enum logic [1:0] {
    CAT_POST    = 2'd0,
    CAT_NONPOST = 2'd1,
    CAT_CPL     = 2'd2,
    CAT_NONE    = 2'd3
  } cat_e;

  localparam int NUM_CAT = 3;
  localparam int BYTES_PER_CREDIT_LOG2 = 2;
endpackage

// File: rtl/tcg_data_need.sv
module tcg_data_need #(
  parameter int LEN_W = 12,
  parameter int DAT_W = 12
) (
  input  logic [LEN_W-1:0] len,
  input  logic             has_data,
  output logic [DAT_W-1:0] need
);
  localparam int SUM_W = LEN_W + 1;
  localparam int RND   = (1 << tcg_pkg::BYTES_PER_CREDIT_LOG2) - 1;

  logic [SUM_W-1:0] rounded;

  always_comb begin
    rounded = ({1'b0, len} + SUM_W'(RND)) >> tcg_pkg::BYTES_PER_CREDIT_LOG2;
    if (has_data) need = DAT_W'(rounded);
    else          need = '0;
  end
endmodule

// File: rtl/tcg_credit_pool.sv
module tcg_credit_pool #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_load,
  input  logic [W-1:0] init_val,
  input  logic         add_en,
  input  logic [W-1:0] add_val,
  input  logic         take_en,
  input  logic [W-1:0] take_val,
  input  logic [W-1:0] need,
  output logic         covers
);
  logic [W-1:0] limit_q, limit_d;
  logic [W-1:0] used_q, used_d;
  logic [W-1:0] avail;
  logic         inf_q, inf_d;
  logic         upd_en;

  always_comb begin
    limit_d = limit_q;
    used_d  = used_q;
    inf_d   = inf_q;
    if (init_load) begin
      limit_d = init_val;
      used_d  = '0;
      inf_d   = (init_val == '0);
    end else begin
      if (add_en && !inf_q)  limit_d = limit_q + add_val;
      if (take_en && !inf_q) used_d  = used_q + take_val;
    end
    upd_en = init_load | add_en | take_en;
    avail  = limit_q - used_q;
    covers = inf_q | (avail >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      used_q  <= '0;
      inf_q   <= 1'b0;
    end else if (upd_en) begin
      limit_q <= limit_d;
      used_q  <= used_d;
      inf_q   <= inf_d;
    end
  end
endmodule

// File: rtl/tx_credit_gate.sv
module tx_credit_gate #(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_valid,
  input  logic [1:0]       init_cat,
  input  logic [HDR_W-1:0] init_hdr,
  input  logic [DAT_W-1:0] init_dat,
  input  logic             init_done,
  input  logic             upd_valid,
  input  logic [1:0]       upd_cat,
  input  logic [HDR_W-1:0] upd_hdr,
  input  logic [DAT_W-1:0] upd_dat,
  input  logic             req_valid,
  input  logic [1:0]       req_cat,
  input  logic             req_has_data,
  input  logic [LEN_W-1:0] req_len,
  output logic             send_ok,
  output logic             tx_take
);
  import tcg_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             link_q, link_d;
  logic [DAT_W-1:0] dat_need;
  logic [NUM_CAT-1:0] hdr_cov, dat_cov;
  logic             cat_ok;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  always_comb link_d = link_q | init_done;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     link_q <= 1'b0;
    else if (!link_q) link_q <= link_d;
  end

  tcg_data_need #(.LEN_W(LEN_W), .DAT_W(DAT_W)) need_i (
    .len      (req_len),
    .has_data (req_has_data),
    .need     (dat_need)
  );

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    logic ld, add, take;
    always_comb begin
      ld   = init_valid && !link_q && (init_cat == 2'(c));
      add  = upd_valid && link_q && (upd_cat == 2'(c));
      take = tx_take && (req_cat == 2'(c));
    end

    tcg_credit_pool #(.W(HDR_W)) hdr_i (
      .clk (clk), .rst_n (rst_s_n),
      .init_load (ld),   .init_val (init_hdr),
      .add_en    (add),  .add_val  (upd_hdr),
      .take_en   (take), .take_val (HDR_W'(1)),
      .need      (HDR_W'(1)),
      .covers    (hdr_cov[c])
    );

    tcg_credit_pool #(.W(DAT_W)) dat_i (
      .clk (clk), .rst_n (rst_s_n),
      .init_load (ld),   .init_val (init_dat),
      .add_en    (add),  .add_val  (upd_dat),
      .take_en   (take), .take_val (dat_need),
      .need      (dat_need),
      .covers    (dat_cov[c])
    );
  end

  always_comb begin
    cat_ok = 1'b0;
    for (int c = 0; c < NUM_CAT; c++) begin
      if (req_cat == 2'(c)) cat_ok = hdr_cov[c] & dat_cov[c];
    end
    send_ok = link_q & cat_ok;
    tx_take = req_valid & send_ok;
  end
endmodule

// File: rtl/tcg_checker.sv
module tcg_checker #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             link_q,
  input logic             init_done,
  input logic             req_valid,
  input logic [1:0]       req_cat,
  input logic             req_has_data,
  input logic [LEN_W-1:0] req_len,
  input logic             send_ok,
  input logic             tx_take
);
  // R7: gate closed while link not up
  p_closed_before_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !link_q |-> !send_ok);

  // R7: link never drops once up
  p_link_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_q |=> link_q);

  // R7: link rises only after init_done
  p_link_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_q) |-> $past(init_done));

  // R4: the unused category code is never sent
  p_no_bad_cat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> (req_cat != 2'd3));

  // R9: a send needs a waiting packet
  p_take_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> req_valid);

  // R5: with the request unchanged, permission is lost only after a consume
  p_drop_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_q && $past(link_q) && $fell(send_ok) && $stable(req_cat) &&
     $stable(req_has_data) && $stable(req_len)) |-> $past(tx_take));
endmodule

bind tx_credit_gate tcg_checker #(.LEN_W(LEN_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_q       (link_q),
  .init_done    (init_done),
  .req_valid    (req_valid),
  .req_cat      (req_cat),
  .req_has_data (req_has_data),
  .req_len      (req_len),
  .send_ok      (send_ok),
  .tx_take      (tx_take)
);

// File: tb/tx_credit_gate_tb_top.sv
`timescale 1ns/1ps
module tx_credit_gate_tb_top;
  localparam int HDR_W = 8;
  localparam int DAT_W = 12;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic init_valid, init_done, upd_valid, req_valid, req_has_data;
  logic [1:0] init_cat, upd_cat, req_cat;
  logic [HDR_W-1:0] init_hdr, upd_hdr;
  logic [DAT_W-1:0] init_dat, upd_dat;
  logic [LEN_W-1:0] req_len;
  logic send_ok, tx_take;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tx_credit_gate #(.HDR_W(HDR_W), .DAT_W(DAT_W), .LEN_W(LEN_W)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .init_valid (init_valid), .init_cat (init_cat), .init_hdr (init_hdr),
    .init_dat (init_dat), .init_done (init_done),
    .upd_valid (upd_valid), .upd_cat (upd_cat), .upd_hdr (upd_hdr), .upd_dat (upd_dat),
    .req_valid (req_valid), .req_cat (req_cat), .req_has_data (req_has_data),
    .req_len (req_len), .send_ok (send_ok), .tx_take (tx_take)
  );

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // look at send_ok without sending
  task automatic probe(input logic [1:0] cat, input bit hasd, input int len,
                       input bit exp, input string tag);
    req_valid = 1'b0; req_cat = cat; req_has_data = hasd; req_len = LEN_W'(len);
    #2;
    chk(send_ok == exp, tag, send_ok, exp);
  endtask

  // offer a packet for one edge; it goes out if permitted
  task automatic offer(input logic [1:0] cat, input bit hasd, input int len,
                       input bit exp, input string tag);
    req_valid = 1'b1; req_cat = cat; req_has_data = hasd; req_len = LEN_W'(len);
    #2;
    chk(send_ok == exp, tag, send_ok, exp);
    chk(tx_take == exp, "R9 take strobe", tx_take, exp);
    tick();
    req_valid = 1'b0;
  endtask

  task automatic adv(input logic [1:0] cat, input int h, input int d);
    init_valid = 1'b1; init_cat = cat; init_hdr = HDR_W'(h); init_dat = DAT_W'(d);
    tick();
    init_valid = 1'b0;
  endtask

  task automatic ret(input logic [1:0] cat, input int h, input int d);
    upd_valid = 1'b1; upd_cat = cat; upd_hdr = HDR_W'(h); upd_dat = DAT_W'(d);
    tick();
    upd_valid = 1'b0;
  endtask

  task automatic t_reset();
    probe(2'd0, 1'b0, 0, 1'b0, "R7 closed after reset");
    chk(tx_take == 1'b0, "R9 no take after reset", tx_take, 0);
  endtask

  task automatic t_init();
    adv(2'd0, 2, 8);
    adv(2'd1, 1, 2);
    adv(2'd2, 0, 0);
    probe(2'd0, 1'b0, 0, 1'b0, "R7 closed before init_done");
    init_done = 1'b1;
    #2;
    chk(send_ok == 1'b0, "R7 closed in init_done cycle", send_ok, 0);
    tick();
    init_done = 1'b0;
    probe(2'd0, 1'b1, 32, 1'b1, "R4 posted 32B fits 8 data");
    probe(2'd0, 1'b1, 33, 1'b0, "R3 posted 33B needs 9 data");
  endtask

  task automatic t_header();
    offer(2'd0, 1'b1, 4, 1'b1, "R3 posted 4B");
    offer(2'd0, 1'b1, 28, 1'b1, "R3 posted 28B");
    probe(2'd0, 1'b0, 0, 1'b0, "R2 empty header pool blocks");
  endtask

  task automatic t_update();
    ret(2'd0, 1, 0);
    probe(2'd0, 1'b0, 0, 1'b1, "R5 header returned");
    probe(2'd0, 1'b1, 4, 1'b0, "R4 data pool short");
    upd_valid = 1'b1; upd_cat = 2'd0; upd_hdr = 8'd1; upd_dat = 12'd1;
    offer(2'd0, 1'b0, 0, 1'b1, "R5 send with return same cycle");
    upd_valid = 1'b0;
    probe(2'd0, 1'b1, 4, 1'b1, "R5 both changes kept");
    probe(2'd0, 1'b1, 5, 1'b0, "R3 5B needs 2 data");
  endtask

  task automatic t_isolate();
    probe(2'd1, 1'b1, 8, 1'b1, "R1 non-posted untouched");
    offer(2'd1, 1'b1, 8, 1'b1, "R1 non-posted send");
    probe(2'd1, 1'b0, 0, 1'b0, "R2 non-posted header spent");
    probe(2'd0, 1'b1, 4, 1'b1, "R1 posted unaffected");
  endtask

  task automatic t_late_init();
    offer(2'd0, 1'b1, 4, 1'b1, "R5 posted last credit");
    adv(2'd0, 0, 0);
    probe(2'd0, 1'b0, 0, 1'b0, "R7 late init ignored");
  endtask

  task automatic t_wrap();
    ret(2'd1, 250, 0);
    for (int i = 0; i < 10; i++) offer(2'd1, 1'b0, 0, 1'b1, "R8 pre-wrap send");
    ret(2'd1, 15, 0);
    probe(2'd1, 1'b0, 0, 1'b1, "R8 limit wrapped below consumed");
    for (int i = 0; i < 255; i++) offer(2'd1, 1'b0, 0, 1'b1, "R8 send across wrap");
    probe(2'd1, 1'b0, 0, 1'b0, "R8 exhausted after 255");
  endtask

  task automatic t_infinite();
    for (int i = 0; i < 300; i++) offer(2'd2, 1'b1, 4095, 1'b1, "R6 unlimited completion");
    ret(2'd2, 5, 5);
    offer(2'd2, 1'b1, 4095, 1'b1, "R6 unlimited after return");
  endtask

  task automatic t_badcat();
    probe(2'd3, 1'b0, 0, 1'b0, "R4 category 3 refused");
    offer(2'd3, 1'b0, 0, 1'b0, "R4 category 3 not sent");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    init_valid = 1'b0; init_cat = '0; init_hdr = '0; init_dat = '0; init_done = 1'b0;
    upd_valid = 1'b0; upd_cat = '0; upd_hdr = '0; upd_dat = '0;
    req_valid = 1'b0; req_cat = '0; req_has_data = 1'b0; req_len = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_init();
    t_header();
    t_update();
    t_isolate();
    t_late_init();
    t_wrap();
    t_infinite();
    t_badcat();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule